// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the stream of column addresses that the burst touches. A request is a single-cycle start pulse carrying a starting column, a burst-length code (2, 4 or 8 beats) and an ordering select (sequential or interleaved). From the next cycle on, the block presents one column address per clock with a valid flag, and raises a last flag on the final beat. The low field of the column (one, two or three bits for lengths 2, 4 and 8) follows the selected ordering and wraps inside the aligned block. The bits above that field name the block and never change during the burst.

A small state machine controls the sequencer. Its states are ST_IDLE (waiting), ST_RUN (emitting beats) and ST_FAULT (one cycle that reports a reserved length code). It has five transitions. ST_IDLE goes to ST_RUN on a start with a legal code, and to ST_FAULT on a start with a reserved code. ST_RUN stays in ST_RUN while the beat is not the last one, and goes back to ST_IDLE on the last beat. ST_FAULT always returns to ST_IDLE. Start pulses are accepted only in ST_IDLE. In every other state they are ignored.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_vld_o, col_last_o and cfg_err_o are 0 and col_o is all zeros.
- R2: A start sampled in the idle state with a legal length code produces the first beat in the next cycle. The length codes are 3'b001 for 2 beats, 3'b010 for 4 beats and 3'b011 for 8 beats. The address of the first beat equals start_col_i.
- R3: A legal burst drives col_vld_o high for exactly as many consecutive cycles as its length, then returns to idle with col_vld_o low.
- R4: col_last_o is high on the final beat of a burst and low on every other cycle.
- R5: With btype_i = 0 (sequential), the low field of beat k is (start low field + k) modulo the burst length.
- R6: With btype_i = 1 (interleaved), the low field of beat k is the start low field XOR k.
- R7: The column bits above the low field equal those of start_col_i on every beat of the burst.
- R8: A start pulse that arrives while a burst is running is ignored. The running burst keeps its addresses and its length, and no further burst follows it.
- R9: A start with a reserved length code (3'b000 or 3'b100 through 3'b111) produces no beats. It raises cfg_err_o for exactly one cycle, the cycle after the start, and a start during that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request pulse |
| start_col_i | input | COL_W | Starting column address |
| blen_code_i | input | 3 | Burst-length code |
| btype_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| col_o | output | COL_W | Column address of the current beat |
| col_vld_o | output | 1 | A beat is present on col_o |
| col_last_o | output | 1 | Final beat of the burst |
| cfg_err_o | output | 1 | One-cycle flag for a reserved length code |

## Verification
The bench runs every length code with both orderings, every start value of the low field and two upper-bit patterns, and computes each expected address arithmetically. This sweep catches the following faults:
- Wrapping at the wrong boundary leaks a carry into the block bits.
- Masking by the wrong width moves the burst out of its aligned block.
- Using addition where XOR belongs, or XOR where addition belongs, gives the wrong beat order.
- An off-by-one beat counter gives a burst that is one beat short or one beat long, or puts the last flag on the wrong beat.

Start pulses are also injected in the middle of a burst and during the error cycle. A design that accepted them would restart or corrupt the sequence, or emit a burst that should never have happened.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int LOW_W = 3;

    localparam logic [2:0] LEN2_CODE = 3'b001;
    localparam logic [2:0] LEN4_CODE = 3'b010;
    localparam logic [2:0] LEN8_CODE = 3'b011;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } bcs_state_e;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
    import bcs_pkg::*;
(
    input  logic [2:0]       code_i,
    output logic [LOW_W-1:0] mask_o,
    output logic             legal_o
);
    always_comb begin
        legal_o = 1'b1;
        unique case (code_i)
            LEN2_CODE: mask_o = 3'b001;
            LEN4_CODE: mask_o = 3'b011;
            LEN8_CODE: mask_o = 3'b111;
            default: begin
                mask_o  = '0;
                legal_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [LOW_W-1:0] beat_i,
    input  logic [LOW_W-1:0] mask_i,
    input  logic             ileave_i,
    output logic [COL_W-1:0] col_o
);
    logic [LOW_W-1:0] low_start;
    logic [LOW_W-1:0] low_next;

    assign low_start = base_i[LOW_W-1:0];

    always_comb begin
        if (ileave_i) begin
            low_next = low_start ^ beat_i;
        end else begin
            low_next = low_start + beat_i;
        end
    end

    generate
        if (COL_W > LOW_W) begin : g_upper
            assign col_o = {base_i[COL_W-1:LOW_W],
                            (low_start & ~mask_i) | (low_next & mask_i)};
        end else begin : g_flat
            assign col_o = (low_start & ~mask_i) | (low_next & mask_i);
        end
    endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_code_i,
    input  logic             btype_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_vld_o,
    output logic             col_last_o,
    output logic             cfg_err_o
);
    bcs_state_e       st_q, st_d;
    logic [LOW_W-1:0] beat_q;
    logic [LOW_W-1:0] mask_q;
    logic [COL_W-1:0] base_q;
    logic             ileave_q;

    logic [LOW_W-1:0] mask_in;
    logic             legal_in;
    logic [COL_W-1:0] col_calc;
    logic             at_last;

    bcs_len_decode u_dec (
        .code_i  (blen_code_i),
        .mask_o  (mask_in),
        .legal_o (legal_in)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_gen (
        .base_i   (base_q),
        .beat_i   (beat_q),
        .mask_i   (mask_q),
        .ileave_i (ileave_q),
        .col_o    (col_calc)
    );

    assign at_last = (beat_q == mask_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d = legal_in ? ST_RUN : ST_FAULT;
                end
            end
            ST_RUN: begin
                if (at_last) begin
                    st_d = ST_IDLE;
                end
            end
            ST_FAULT: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            beat_q   <= '0;
            mask_q   <= '0;
            base_q   <= '0;
            ileave_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start_i) begin
                beat_q   <= '0;
                mask_q   <= mask_in;
                base_q   <= start_col_i;
                ileave_q <= btype_i;
            end else if (st_q == ST_RUN) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        col_o      = '0;
        col_vld_o  = 1'b0;
        col_last_o = 1'b0;
        cfg_err_o  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                col_o      = col_calc;
                col_vld_o  = 1'b1;
                col_last_o = at_last;
            end
            ST_FAULT: cfg_err_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       blen_code_i,
    input logic [COL_W-1:0] col_o,
    input logic             col_vld_o,
    input logic             col_last_o,
    input logic             cfg_err_o
);
    logic code_ok;
    logic idle_seen;
    assign code_ok   = (blen_code_i == 3'b001) || (blen_code_i == 3'b010) ||
                       (blen_code_i == 3'b011);
    assign idle_seen = !col_vld_o && !cfg_err_o;

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        col_last_o |-> col_vld_o); // R4
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle_seen && code_ok) |=> (col_vld_o && col_o == $past(start_col_i))); // R2
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld_o && !col_last_o) |=> (col_vld_o && col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]))); // R7
    AST_RESERVED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle_seen && !code_ok) |=> (cfg_err_o && !col_vld_o)); // R9
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> (!cfg_err_o && !col_vld_o)); // R9
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        col_last_o |=> !col_vld_o); // R3
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_code_i (blen_code_i),
    .col_o       (col_o),
    .col_vld_o   (col_vld_o),
    .col_last_o  (col_last_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_code_i = '0;
    logic             btype_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             col_vld_o;
    logic             col_last_o;
    logic             cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_code_i(blen_code_i), .btype_i(btype_i), .col_o(col_o),
        .col_vld_o(col_vld_o), .col_last_o(col_last_o), .cfg_err_o(cfg_err_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 200000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 200000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drives one request; poke=1 injects a second start mid-burst (R8) or during the error cycle (R9)
    task automatic run_burst(input logic [2:0] code, input logic typ,
                             input logic [COL_W-1:0] col, input logic poke);
        int n;
        logic [COL_W-1:0] m;
        logic [COL_W-1:0] e;
        n = (code == 3'b001) ? 2 : (code == 3'b010) ? 4 : (code == 3'b011) ? 8 : 0;
        m = (n == 0) ? '0 : COL_W'(n - 1);
        @(negedge clk);
        start_i = 1'b1; start_col_i = col; blen_code_i = code; btype_i = typ;
        @(negedge clk);
        start_i = 1'b0;
        if (n == 0) begin
            check("R9 err raised", {31'd0, cfg_err_o}, 32'd1);
            check("R9 no beat", {31'd0, col_vld_o}, 32'd0);
            if (poke) begin
                start_i = 1'b1; blen_code_i = 3'b011; start_col_i = ~col;
            end
            @(negedge clk);
            start_i = 1'b0;
            check("R9 err one cycle", {31'd0, cfg_err_o}, 32'd0);
            check("R9 start in err ignored", {31'd0, col_vld_o}, 32'd0);
        end else begin
            for (int k = 0; k < n; k++) begin
                if (typ) e = (col & ~m) | ((col ^ COL_W'(k)) & m);
                else     e = (col & ~m) | ((col + COL_W'(k)) & m);
                check(typ ? "R6 interleaved col" : "R5 sequential col", 32'(col_o), 32'(e));
                check("R7 upper bits", 32'(col_o >> 3), 32'(col >> 3));
                check("R3 valid", {31'd0, col_vld_o}, 32'd1);
                check("R4 last", {31'd0, col_last_o}, {31'd0, k == n - 1});
                if (k == 0) check("R2 first beat", 32'(col_o), 32'(col));
                if (poke && k == 1) begin
                    start_i = 1'b1; start_col_i = ~col; blen_code_i = 3'b011; btype_i = ~typ;
                end
                @(negedge clk);
                start_i = 1'b0; btype_i = typ;
            end
            check("R3 idle after burst", {31'd0, col_vld_o}, 32'd0);
            check("R8 no extra burst", {30'd0, cfg_err_o, col_last_o}, 32'd0);
        end
    endtask

    initial begin
        #1;
        check("R1 reset vld", {31'd0, col_vld_o}, 32'd0);
        check("R1 reset last", {31'd0, col_last_o}, 32'd0);
        check("R1 reset err", {31'd0, cfg_err_o}, 32'd0);
        check("R1 reset col", 32'(col_o), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++)
            for (int t = 0; t < 2; t++)
                for (int s = 0; s < 8; s++)
                    for (int u = 0; u < 2; u++)
                        run_burst(3'(c), t[0],
                                  (u == 0) ? COL_W'(s) : (COL_W'(10'h3A8) | COL_W'(s)),
                                  u == 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule